// File: doc/BRIEF.md
# Burst Payload Checker

This block sits behind a burst-mode clock and data recovery front end and judges every upstream burst it delivers. After the start of a burst it ignores a fixed number of bits while the front end settles its sampling phase. It then searches the incoming bits for a fixed delimiter word that follows a preamble of arbitrary length, which may be empty. From the bit after the delimiter it compares a fixed number of payload bits against a locally generated PRBS-7 sequence. That sequence restarts from its seed on every delimiter.

Three saturating counters collect the results: bursts seen, bursts with at least one fault, and total bit errors. Bursts that never present a delimiter, and bursts cut short by the next burst, are charged to these counters as errors. A skipped, merged or misaligned burst therefore always becomes visible in the statistics. A single clear pulse resets all three counters together.

Top module: `burst_payload_checker`

## Requirements
- R1: After a `burst_start` pulse, the first `LOCK_BITS` valid bits are never searched or compared, even when they contain the delimiter pattern.
- R2: After the lock interval, the delimiter (`DELIM`, `DELIM_W` bits, most significant bit received first) is found by exact match after a preamble of any length from 0 up to `hunt_window - DELIM_W` bits. A match on the last bit of the window still counts as found.
- R3: The payload bit at index j after the delimiter is compared with bit j of a PRBS-7 sequence. The sequence state s starts at `SEED`, each expected bit is s[6]^s[5], and after each payload bit s becomes {s[5:0], s[6]^s[5]}. Each mismatch adds one to `bit_err_cnt`.
- R4: A burst whose `PAYLOAD_LEN` payload bits all arrive adds one to `burst_cnt` on its last bit. If any of its bits mismatched, it also adds one to `err_burst_cnt`.
- R5: If `hunt_window` valid bits arrive after the lock interval without a delimiter match, the burst is lost. It adds one to `burst_cnt`, one to `err_burst_cnt` and `PAYLOAD_LEN` to `bit_err_cnt`, and `burst_lost` is high for exactly one cycle.
- R6: A `burst_start` that arrives while a burst is still in progress ends that burst as errored. If the old burst was in its payload, the unchecked remainder of `PAYLOAD_LEN` is added to `bit_err_cnt`. If it was still in lock or delimiter search, it is treated as lost, as in R5.
- R7: Each counter saturates at all ones and holds there.
- R8: When `clear_stats` is high, each counter loads only the increment from that same cycle, so an event that coincides with the clear is kept.
- R9: After reset, all counters read zero and `burst_lost` is low.
- R10: Cycles with `rx_valid` low do not advance the lock count, the search or the payload comparison. In the `burst_start` cycle `rx_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | One-cycle marker that a new burst begins; carries no data |
| rx_valid | input | 1 | `rx_bit` holds a recovered bit this cycle |
| rx_bit | input | 1 | Recovered data bit |
| hunt_window | input | WIN_W | Number of bits allowed for preamble plus delimiter |
| clear_stats | input | 1 | Pulse that clears all counters |
| burst_cnt | output | CNT_W | Bursts seen |
| bit_err_cnt | output | CNT_W | Accumulated bit errors |
| err_burst_cnt | output | CNT_W | Bursts with any error, lost or cut short |
| burst_lost | output | 1 | One-cycle pulse when a burst ends without a delimiter |

## Verification
A counter clear and the accounting of a finished burst can fall in the same cycle. The bench provokes this by raising `clear_stats` together with the final payload bit of a burst whose last bit is flipped. The collision is judged correct when the counters then show exactly that burst: one burst, one errored burst and one bit error. A related collision is also exercised: a new `burst_start` landing on a burst that is still in its payload or still searching. The bench checks that the charged error count equals the unchecked remainder.

// File: rtl/bpc_pkg.sv
// Shared types for the burst payload checker.
package bpc_pkg;
    // Phase of the burst currently being received.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOCK = 2'd1,
        ST_HUNT = 2'd2,
        ST_PAY  = 2'd3
    } bpc_state_e;
endpackage

// File: rtl/bpc_prbs7.sv
// PRBS-7 reference generator (x^7 + x^6 + 1).
// Presents the expected bit combinationally from the current state.
// 'restart' reloads the seed and has priority over 'advance'.
// Assumes SEED is nonzero.
module bpc_prbs7 #(
    parameter logic [6:0] SEED = 7'h7F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic advance,
    output logic exp_bit
);
    logic [6:0] lfsr_q;

    assign exp_bit = lfsr_q[6] ^ lfsr_q[5];

    // Seed on reset or restart, step once per consumed payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            lfsr_q <= SEED;
        end else if (advance) begin
            lfsr_q <= {lfsr_q[5:0], lfsr_q[6] ^ lfsr_q[5]};
        end
    end

    // R3: the reference register never falls into the all-zero lock-up state.
    a_r3_prbs_alive: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 7'd0);
endmodule

// File: rtl/bpc_delim.sv
// Exact-match delimiter detector.
// Shifts in bits (newest at the LSB) and reports a hit on the bit that
// completes DELIM. Only bits shifted since the last 'clr' may contribute,
// so bits from the lock interval can never form part of a match.
module bpc_delim #(
    parameter int DELIM_W = 16,
    parameter logic [DELIM_W-1:0] DELIM = 16'hB61C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift_en,
    input  logic din,
    output logic hit
);
    localparam int FW = $clog2(DELIM_W + 1);

    logic [DELIM_W-1:0] sr_q;
    logic [FW-1:0]      fill_q;
    logic               full;
    logic [DELIM_W-1:0] window;

    assign full   = fill_q >= FW'(DELIM_W - 1);
    assign window = {sr_q[DELIM_W-2:0], din};
    assign hit    = shift_en && full && (window == DELIM);

    // Hold the most recent bits and count how many are valid.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            sr_q <= window;
            if (!full) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // R2: the fill count stays within the delimiter length.
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FW'(DELIM_W - 1));
endmodule

// File: rtl/bpc_stats.sv
// Saturating statistics counters: bursts, errored bursts, bit errors.
// A clear loads each counter with only the increment of the same cycle,
// so no event is lost when a clear coincides with it.
module bpc_stats #(
    parameter int CNT_W = 16,
    parameter int ADD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_burst,
    input  logic             ev_errb,
    input  logic [ADD_W-1:0] add_bits,
    output logic [CNT_W-1:0] burst_cnt,
    output logic [CNT_W-1:0] err_burst_cnt,
    output logic [CNT_W-1:0] bit_err_cnt
);
    localparam int NCNT = 3;
    localparam int SW   = ((ADD_W > CNT_W) ? ADD_W : CNT_W) + 1;
    localparam logic [SW-1:0]    MAXV = SW'({CNT_W{1'b1}});
    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [NCNT];
    logic [ADD_W-1:0] inc   [NCNT];

    // Add with a ceiling at all ones.
    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [ADD_W-1:0] b);
        logic [SW-1:0] s;
        s = SW'(a) + SW'(b);
        return (s > MAXV) ? TOP : s[CNT_W-1:0];
    endfunction

    assign inc[0] = ADD_W'(ev_burst);
    assign inc[1] = ADD_W'(ev_errb);
    assign inc[2] = add_bits;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        // Accumulate one statistic, restarting from zero on a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else begin
                cnt_q[g] <= sat_add(clr ? '0 : cnt_q[g], inc[g]);
            end
        end

        // R7: once at the ceiling, a counter stays there until cleared.
        a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cnt_q[g]) == TOP && !$past(clr)) |-> cnt_q[g] == TOP);
        // R8: a clear with no concurrent event leaves the counter at zero.
        a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(clr) && $past(inc[g]) == '0) |-> cnt_q[g] == '0);
        // R7: without a clear a counter never decreases.
        a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(clr)) |-> cnt_q[g] >= $past(cnt_q[g]));
    end

    assign burst_cnt     = cnt_q[0];
    assign err_burst_cnt = cnt_q[1];
    assign bit_err_cnt   = cnt_q[2];
endmodule

// File: rtl/burst_payload_checker.sv
// Burst payload checker.
// Sequences each burst through lock skip, delimiter search and payload
// comparison, and turns the outcome into counter increments.
// Assumes LOCK_BITS >= 2, PAYLOAD_LEN >= 2, DELIM_W >= 2, and hunt_window >= DELIM_W.
module burst_payload_checker #(
    parameter int LOCK_BITS   = 32,
    parameter int DELIM_W     = 16,
    parameter logic [DELIM_W-1:0] DELIM = 16'hB61C,
    parameter int PAYLOAD_LEN = 48,
    parameter logic [6:0] SEED = 7'h7F,
    parameter int WIN_W       = 12,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_start,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic [WIN_W-1:0] hunt_window,
    input  logic             clear_stats,
    output logic [CNT_W-1:0] burst_cnt,
    output logic [CNT_W-1:0] bit_err_cnt,
    output logic [CNT_W-1:0] err_burst_cnt,
    output logic             burst_lost
);
    import bpc_pkg::*;

    localparam int LW = $clog2(LOCK_BITS + 1);
    localparam int PW = $clog2(PAYLOAD_LEN + 1);

    bpc_state_e       state_q, state_d;
    logic [LW-1:0]    lock_cnt_q;
    logic [WIN_W-1:0] hunt_cnt_q;
    logic [PW-1:0]    pay_cnt_q;
    logic             burst_err_q;

    logic             bit_ok;
    logic             lock_last, hunt_end, pay_last;
    logic             det_clr, det_shift, det_hit;
    logic             exp_bit, mis;
    logic             ev_burst, ev_errb, lost;
    logic [PW-1:0]    add_bits;

    assign bit_ok    = rx_valid && !burst_start;
    assign lock_last = lock_cnt_q == LW'(LOCK_BITS - 1);
    assign hunt_end  = ({1'b0, hunt_cnt_q} + 1'b1) >= {1'b0, hunt_window};
    assign pay_last  = pay_cnt_q == PW'(PAYLOAD_LEN - 1);
    assign det_clr   = (state_q == ST_LOCK) && bit_ok && lock_last;
    assign det_shift = (state_q == ST_HUNT) && bit_ok;
    assign mis       = rx_bit ^ exp_bit;

    bpc_delim #(
        .DELIM_W (DELIM_W),
        .DELIM   (DELIM)
    ) u_delim (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (det_clr),
        .shift_en (det_shift),
        .din      (rx_bit),
        .hit      (det_hit)
    );

    bpc_prbs7 #(
        .SEED (SEED)
    ) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (det_hit),
        .advance ((state_q == ST_PAY) && bit_ok),
        .exp_bit (exp_bit)
    );

    // Derive this cycle's counter increments and the next phase.
    always_comb begin
        state_d  = state_q;
        ev_burst = 1'b0;
        ev_errb  = 1'b0;
        add_bits = '0;
        lost     = 1'b0;
        if (burst_start) begin
            state_d = ST_LOCK;
            unique case (state_q)
                ST_LOCK, ST_HUNT: begin
                    ev_burst = 1'b1;
                    ev_errb  = 1'b1;
                    add_bits = PW'(PAYLOAD_LEN);
                    lost     = 1'b1;
                end
                ST_PAY: begin
                    ev_burst = 1'b1;
                    ev_errb  = 1'b1;
                    add_bits = PW'(PAYLOAD_LEN) - pay_cnt_q;
                end
                default: ;
            endcase
        end else if (rx_valid) begin
            unique case (state_q)
                ST_LOCK: if (lock_last) state_d = ST_HUNT;
                ST_HUNT: begin
                    if (det_hit) begin
                        state_d = ST_PAY;
                    end else if (hunt_end) begin
                        state_d  = ST_IDLE;
                        ev_burst = 1'b1;
                        ev_errb  = 1'b1;
                        add_bits = PW'(PAYLOAD_LEN);
                        lost     = 1'b1;
                    end
                end
                ST_PAY: begin
                    add_bits = PW'(mis);
                    if (pay_last) begin
                        state_d  = ST_IDLE;
                        ev_burst = 1'b1;
                        ev_errb  = burst_err_q | mis;
                    end
                end
                default: ;
            endcase
        end
    end

    // Phase register and the per-phase bit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lock_cnt_q  <= '0;
            hunt_cnt_q  <= '0;
            pay_cnt_q   <= '0;
            burst_err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (burst_start) begin
                lock_cnt_q <= '0;
            end else if (bit_ok) begin
                unique case (state_q)
                    ST_LOCK: begin
                        lock_cnt_q <= lock_cnt_q + 1'b1;
                        hunt_cnt_q <= '0;
                    end
                    ST_HUNT: begin
                        hunt_cnt_q  <= hunt_cnt_q + 1'b1;
                        pay_cnt_q   <= '0;
                        burst_err_q <= 1'b0;
                    end
                    ST_PAY: begin
                        pay_cnt_q   <= pay_cnt_q + 1'b1;
                        burst_err_q <= burst_err_q | mis;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register the lost-burst pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_lost <= 1'b0;
        end else begin
            burst_lost <= lost;
        end
    end

    bpc_stats #(
        .CNT_W (CNT_W),
        .ADD_W (PW)
    ) u_stats (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (clear_stats),
        .ev_burst      (ev_burst),
        .ev_errb       (ev_errb),
        .add_bits      (add_bits),
        .burst_cnt     (burst_cnt),
        .err_burst_cnt (err_burst_cnt),
        .bit_err_cnt   (bit_err_cnt)
    );

    // R1: nothing is charged while the lock interval runs.
    a_r1_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !burst_start) |-> (add_bits == '0 && !ev_burst));
    // R2: payload cannot begin before a full delimiter has been searched.
    a_r2_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && bit_ok && hunt_cnt_q < WIN_W'(DELIM_W - 1)) |=> state_q != ST_PAY);
    // R5: the lost indication is a single-cycle pulse.
    a_r5_lost_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        burst_lost |=> !burst_lost);
    // R4: an errored burst is always also a counted burst.
    a_r4_errb_implies_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ev_errb |-> ev_burst);
    // R10: an idle cycle leaves the phase untouched.
    a_r10_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !burst_start) |=> $stable(state_q));
endmodule

// File: tb/burst_payload_checker_bench.sv
module burst_payload_checker_bench;
    localparam int LOCK = 32;
    localparam int DW   = 16;
    localparam logic [15:0] DLM = 16'hB61C;
    localparam int PL   = 20;
    localparam int WW   = 8;
    localparam int CW   = 8;
    localparam int WIN  = 40;
    localparam int MAXC = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_start = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic clear_stats = 1'b0;
    logic [WW-1:0] hunt_window = WW'(WIN);
    logic [CW-1:0] burst_cnt, bit_err_cnt, err_burst_cnt;
    logic burst_lost;

    int total = 0;
    int bad = 0;
    int e_b = 0, e_eb = 0, e_bits = 0, e_lost = 0;
    int lost_seen = 0;

    always #2 clk = ~clk;

    burst_payload_checker #(
        .LOCK_BITS (LOCK), .DELIM_W (DW), .DELIM (DLM), .PAYLOAD_LEN (PL),
        .SEED (7'h7F), .WIN_W (WW), .CNT_W (CW)
    ) u_burst_payload_checker (
        .clk (clk), .rst_n (rst_n), .burst_start (burst_start),
        .rx_valid (rx_valid), .rx_bit (rx_bit), .hunt_window (hunt_window),
        .clear_stats (clear_stats), .burst_cnt (burst_cnt),
        .bit_err_cnt (bit_err_cnt), .err_burst_cnt (err_burst_cnt),
        .burst_lost (burst_lost)
    );

    // Count lost pulses away from the active edge.
    always @(negedge clk) if (rst_n && burst_lost) lost_seen++;

    function automatic logic prbs_bit(input int j);
        logic [6:0] s = 7'h7F;
        for (int k = 0; k < j; k++) s = {s[5:0], s[6] ^ s[5]};
        return s[6] ^ s[5];
    endfunction

    function automatic int satv(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic bump(input int b, input int eb, input int bits);
        e_b = satv(e_b + b); e_eb = satv(e_eb + eb); e_bits = satv(e_bits + bits);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic b, input logic clr);
        @(negedge clk);
        burst_start = 1'b0; rx_valid = 1'b1; rx_bit = b; clear_stats = clr;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            burst_start = 1'b0; rx_valid = 1'b0; clear_stats = 1'b0;
        end
    endtask

    task automatic start_lock(input bit dlm_pat);
        @(negedge clk);
        burst_start = 1'b1; rx_valid = 1'b0; clear_stats = 1'b0;
        for (int i = 0; i < LOCK; i++)
            put(dlm_pat ? DLM[15 - (i % 16)] : logic'(i % 2), 1'b0);
    endtask

    // Lock, preamble, delimiter, then plen payload bits.
    task automatic send_burst(input int pre, input int flip, input int plen,
                              input bit gaps, input bit clr_last, input bit dlm_pat);
        start_lock(dlm_pat);
        for (int i = 0; i < pre; i++) put(logic'((i + 1) % 2), 1'b0);
        for (int i = 0; i < DW; i++) put(DLM[DW - 1 - i], 1'b0);
        for (int j = 0; j < plen; j++) begin
            if (gaps && (j % 2 == 1)) gap(1);
            put(prbs_bit(j) ^ (j == flip), clr_last && (j == plen - 1));
        end
    endtask

    task automatic check_all(input string req);
        gap(3);
        chk({req, " bursts"}, int'(burst_cnt), e_b);
        chk({req, " errored"}, int'(err_burst_cnt), e_eb);
        chk({req, " biterrs"}, int'(bit_err_cnt), e_bits);
        chk({req, " lost"}, lost_seen, e_lost);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        gap(1);
        // R9: reset state.
        chk("R9 bursts", int'(burst_cnt), 0);
        chk("R9 biterrs", int'(bit_err_cnt), 0);
        chk("R9 errored", int'(err_burst_cnt), 0);
        chk("R9 lost", int'(burst_lost), 0);

        // R2: every preamble length up to the window edge, clean payload.
        for (int p = 0; p <= WIN - DW; p++) begin
            send_burst(p, -1, PL, 1'b0, 1'b0, 1'b0);
            bump(1, 0, 0);
            check_all("R2");
        end

        // R3 R4: single flipped bit at every payload index.
        for (int f = 0; f < PL; f++) begin
            send_burst(f % 5, f, PL, 1'b0, 1'b0, 1'b0);
            bump(1, 1, 1);
            check_all("R3_R4");
        end

        // R1: lock interval filled with the delimiter pattern is ignored.
        send_burst(3, -1, PL, 1'b0, 1'b0, 1'b1);
        bump(1, 0, 0);
        check_all("R1");

        // R10: idle cycles inside the payload do not disturb comparison.
        send_burst(6, -1, PL, 1'b1, 1'b0, 1'b0);
        bump(1, 0, 0);
        check_all("R10");

        // R6: payload cut short by the next burst.
        send_burst(3, -1, 7, 1'b0, 1'b0, 1'b0);
        send_burst(2, -1, PL, 1'b0, 1'b0, 1'b0);
        bump(1, 1, PL - 7); bump(1, 0, 0);
        check_all("R6 payload");

        // R6: burst restarted during delimiter search counts as lost.
        start_lock(1'b0);
        for (int i = 0; i < 5; i++) put(logic'(i % 2), 1'b0);
        send_burst(1, -1, PL, 1'b0, 1'b0, 1'b0);
        bump(1, 1, PL); bump(1, 0, 0); e_lost++;
        check_all("R6 hunt");

        // R5: window expires with no delimiter.
        start_lock(1'b0);
        for (int i = 0; i < WIN; i++) put(logic'((i + 1) % 2), 1'b0);
        bump(1, 1, PL); e_lost++;
        check_all("R5");

        // R8: plain clear, then clear landing on the final errored bit.
        @(negedge clk); clear_stats = 1'b1;
        gap(1);
        e_b = 0; e_eb = 0; e_bits = 0;
        check_all("R8 clear");
        send_burst(4, PL - 1, PL, 1'b0, 1'b1, 1'b0);
        bump(1, 1, 1);
        check_all("R8 collide");

        // R7: repeated lost bursts drive the bit-error counter to its ceiling.
        for (int k = 0; k < 14; k++) begin
            start_lock(1'b0);
            for (int i = 0; i < WIN; i++) put(logic'((i + 1) % 2), 1'b0);
            bump(1, 1, PL); e_lost++;
        end
        check_all("R7");
        chk("R7 ceiling", int'(bit_err_cnt), MAXC);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule